// File: doc/BRIEF.md
# Parallel-Lane Sine Synthesizer with Aligned Start

This block produces a sine waveform for a converter whose sample clock runs at a fixed multiple of the core clock. On every core clock it emits `CLK_RATIO` samples side by side. Lane `k` owns its own 16-bit phase accumulator. Each lane starts `k` frequency-word steps ahead of lane 0, so reading the lanes in order, cycle after cycle, gives one unbroken waveform.

A synchronization input parks the generator. While it is held, every sample is zero and the output stream is marked invalid. When it is released, all lane accumulators are loaded in the same clock edge from the initial-phase and frequency inputs. A short synchronization pulse is stretched inside the block to at least `CLK_RATIO` cycles, so a glitch-length pulse cannot leave some lanes loaded and others not. Reset behaves as a synchronization event of zero length.

The output is a stream with a valid flag and no ready input. The converter takes a word on every core clock. A sink that cannot keep up has no way to slow the block, and samples in cycles it misses are lost. The enable input pauses the stream without losing phase.

Top module: `mlane_dds`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low and all samples are zero. After reset is released with `sync_in` low and `enable` high, `out_valid` first reads high after the (`CLK_RATIO`+3)-th rising edge.
- R2: At the load edge, lane `k` is set to `init_phase + k*freq_word`, modulo 2^16. The first valid output word carries, in lane `k`, the amplitude of that phase.
- R3: Once the block is holding, whether from sync, its stretch or reset, `out_valid` is low and every sample is zero, starting two edges later and lasting until two edges after the load.
- R4: On each edge where the block is running and `enable` is high, every lane advances by `CLK_RATIO*freq_word`. Output word `n` after the load therefore carries, in lane `k`, the amplitude of `init_phase + (k + n*CLK_RATIO)*freq_word`. The output lags the accumulators by two edges.
- R5: Let `sync_in` be first sampled high at edge 1 and stay high for `L` edges. The load then happens at edge `max(L, CLK_RATIO)+1`, and `out_valid` first reads high again after edge `max(L, CLK_RATIO)+3`.
- R6: An edge with `enable` low leaves every accumulator unchanged. Two edges later, `out_valid` is low and the samples are zero. When `enable` returns, the waveform resumes at the held phase.
- R7: Amplitude uses phase bits [15:14] as the quadrant and bits [13:8] as the index `i`. The magnitude is `T(i)` in even quadrants and `T(63-i)` in odd ones, with `T(j) = floor(2047*sin(pi*(j+0.5)/128)+0.5)`. Quadrants 2 and 3 are negated. Lane `k` occupies `out_samples[12k+11:12k]` as a two's-complement value.
- R8: No sample ever has a magnitude above 2047, so the code -2048 never appears.
- R9: If `sync_in` rises again while the stretch is still running, the block keeps holding without restarting its count. It loads on the first edge where `sync_in` is low and at least `CLK_RATIO` holding edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run/pause for the accumulators and the stream |
| sync_in | input | 1 | Hold request; releasing it starts all lanes together |
| freq_word | input | 16 | Phase step per converter sample |
| init_phase | input | 16 | Phase of lane 0 at the load |
| out_valid | output | 1 | The current output word carries live samples |
| out_samples | output | 48 | Four 12-bit signed samples, lane 0 in the low bits |

## Verification
The assertions assume that `freq_word` does not change on the edge that loads the lanes. The lane-spacing check compares the accumulators with the word that was present at the load. They also assume that `rst_n` is released clear of a clock edge. The stimulus changes every input only on the falling clock edge and changes the frequency word only during a hold. Sync pulse lengths sweep from 1 to 7 cycles, covering both sides of the stretch threshold. A re-asserted sync and pauses of `enable` are applied only between complete load sequences.

// File: rtl/mlane_dds_pkg.sv
package mlane_dds_pkg;

  localparam real PI_C = 3.141592653589793;

  // Quarter-wave magnitude for entry idx of a depth-entry table,
  // sampled at the middle of each index step for exact mirror symmetry.
  function automatic int qwave_entry(input int idx, input int depth, input int amp_w);
    real ang;
    real peak;
    ang  = PI_C * (real'(idx) + 0.5) / (2.0 * real'(depth));
    peak = (2.0 ** (amp_w - 1)) - 1.0;
    return $rtoi(peak * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/mlane_sync_gate.sv
module mlane_sync_gate #(
  parameter int CLK_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic hold_o,
  output logic load_o
);
  localparam int CW = $clog2(CLK_RATIO + 1);
  localparam logic [CW-1:0] CNT_MIN = CW'(CLK_RATIO);

  logic          hold_q;
  logic [CW-1:0] cnt_q;

  assign hold_o = hold_q;
  assign load_o = hold_q & ~sync_in & (cnt_q >= CNT_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q) begin
      if (cnt_q != CNT_MIN) cnt_q <= cnt_q + 1'b1;
      if (load_o) hold_q <= 1'b0;
    end else if (sync_in) begin
      hold_q <= 1'b1;
      cnt_q  <= CW'(1);
    end
  end

  // R3: a sampled sync request always leaves the block holding
  p_sync_enters_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> hold_q);

  // R9: release never happens while sync was requested
  p_release_needs_low_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> !$past(sync_in));

endmodule

// File: rtl/mlane_phase_acc.sv
module mlane_phase_acc #(
  parameter int PHASE_W   = 16,
  parameter int CLK_RATIO = 4,
  parameter int LANE      = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               advance,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [PHASE_W-1:0] init_phase,
  output logic [PHASE_W-1:0] phase
);
  localparam logic [PHASE_W-1:0] LANE_MUL = PHASE_W'(LANE);
  localparam logic [PHASE_W-1:0] STEP_MUL = PHASE_W'(CLK_RATIO);

  logic [PHASE_W-1:0] phase_q;
  assign phase = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (load)    phase_q <= init_phase + LANE_MUL * freq_word;
    else if (advance) phase_q <= phase_q + STEP_MUL * freq_word;
  end

  // R6: with neither load nor advance the phase is frozen
  p_frozen_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(phase_q));

endmodule

// File: rtl/mlane_sine_lane.sv
module mlane_sine_lane #(
  parameter int PHASE_W = 16,
  parameter int LUT_AW  = 6,
  parameter int AMP_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PHASE_W-1:0]      phase,
  input  logic                    live,
  output logic signed [AMP_W-1:0] sample
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam int MAG_W = AMP_W - 1;
  localparam int IDX_HI = PHASE_W - 3;

  logic [MAG_W-1:0] qtab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    assign qtab[g] = MAG_W'(mlane_dds_pkg::qwave_entry(g, DEPTH, AMP_W));
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [LUT_AW-1:0] addr;
  logic              unused_low;

  assign quad       = phase[PHASE_W-1 -: 2];
  assign idx        = phase[IDX_HI -: LUT_AW];
  assign addr       = quad[0] ? ~idx : idx;
  assign unused_low = ^phase[IDX_HI-LUT_AW:0];

  // stage 1: table read
  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic             live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      neg_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      mag_q  <= qtab[addr];
      neg_q  <= quad[1];
      live_q <= live;
    end
  end

  // stage 2: sign and zero gate
  logic signed [AMP_W-1:0] sample_q;
  logic signed [AMP_W-1:0] signed_mag;

  assign signed_mag = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sample_q <= '0;
    else if (live_q) sample_q <= signed_mag;
    else             sample_q <= '0;
  end

  assign sample = sample_q;

  // R8: magnitude never reaches the most negative code
  p_amp_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_q != {1'b1, {(AMP_W-1){1'b0}}});

  // R3: a non-live phase produces a zero sample two edges later
  p_zero_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> ##2 (sample_q == '0));

endmodule

// File: rtl/mlane_dds.sv
module mlane_dds #(
  parameter int CLK_RATIO = 4,
  parameter int PHASE_W   = 16,
  parameter int LUT_AW    = 6,
  parameter int AMP_W     = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         sync_in,
  input  logic [PHASE_W-1:0]           freq_word,
  input  logic [PHASE_W-1:0]           init_phase,
  output logic                         out_valid,
  output logic [CLK_RATIO*AMP_W-1:0]   out_samples
);
  localparam int BUS_W = CLK_RATIO * AMP_W;

  logic hold;
  logic load;
  logic advance;
  logic [PHASE_W-1:0] acc [CLK_RATIO];
  logic signed [AMP_W-1:0] lane_sample [CLK_RATIO];

  mlane_sync_gate #(.CLK_RATIO(CLK_RATIO)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .hold_o  (hold),
    .load_o  (load)
  );

  assign advance = ~hold & enable;

  for (genvar k = 0; k < CLK_RATIO; k++) begin : g_lane
    mlane_phase_acc #(
      .PHASE_W   (PHASE_W),
      .CLK_RATIO (CLK_RATIO),
      .LANE      (k)
    ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .advance    (advance),
      .freq_word  (freq_word),
      .init_phase (init_phase),
      .phase      (acc[k])
    );

    mlane_sine_lane #(
      .PHASE_W (PHASE_W),
      .LUT_AW  (LUT_AW),
      .AMP_W   (AMP_W)
    ) u_amp (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (acc[k]),
      .live   (advance),
      .sample (lane_sample[k])
    );

    assign out_samples[k*AMP_W +: AMP_W] = lane_sample[k];

    // R2: after a load, lane spacing equals k frequency words
    p_lane_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (acc[k] - acc[0]) == (PHASE_W'(k) * $past(freq_word)));

    // R4: outside a load all lanes move by the same step
    p_spacing_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (acc[k] - acc[0]) == $past(acc[k] - acc[0]));
  end

  // validity pipeline matched to the two amplitude stages
  logic [1:0] live_pipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_pipe <= '0;
    else        live_pipe <= {live_pipe[0], advance};
  end
  assign out_valid = live_pipe[1];

  // R3: holding clears validity two edges later
  p_hold_gates_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ##2 !out_valid);

  // R6: a paused edge clears validity two edges later
  p_pause_gates_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> ##2 !out_valid);

  // R3: invalid output words are all zero
  p_invalid_is_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_samples == BUS_W'(0)));

endmodule

// File: tb/mlane_dds_tb.sv
module mlane_dds_tb;
  localparam int CR = 4;
  localparam int PW = 16;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic sync_in = 1'b0;
  logic [PW-1:0] freq_word = '0;
  logic [PW-1:0] init_phase = '0;
  logic out_valid;
  logic [CR*AW-1:0] out_samples;

  always #10 clk = ~clk;

  mlane_dds #(.CLK_RATIO(CR), .PHASE_W(PW), .LUT_AW(6), .AMP_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_in(sync_in),
    .freq_word(freq_word), .init_phase(init_phase),
    .out_valid(out_valid), .out_samples(out_samples)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // requirement model state
  bit m_hold;
  int m_cnt;
  logic [PW-1:0] m_acc [CR];
  bit m_v1, m_v2;
  int m_s1 [CR];
  int m_s2 [CR];

  function automatic int amp_of(input logic [PW-1:0] ph);
    int q, i, a, m;
    q = int'(ph[15:14]);
    i = int'(ph[13:8]);
    a = (q % 2 == 1) ? 63 - i : i;
    m = $rtoi(2047.0 * $sin(3.141592653589793 * (real'(a) + 0.5) / 128.0) + 0.5);
    return (q >= 2) ? -m : m;
  endfunction

  function automatic int lane_out(input int k);
    return int'($signed(out_samples[k*AW +: AW]));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_hold = 1'b1; m_cnt = 0; m_v1 = 1'b0; m_v2 = 1'b0;
    for (int k = 0; k < CR; k++) begin
      m_acc[k] = '0; m_s1[k] = 0; m_s2[k] = 0;
    end
  endtask

  // one clock edge: model update, then comparison at the falling edge
  task automatic step(input string tag);
    bit ld;
    @(posedge clk);
    m_v2 = m_v1;
    for (int k = 0; k < CR; k++) m_s2[k] = m_v1 ? m_s1[k] : 0;
    m_v1 = !m_hold && enable;
    for (int k = 0; k < CR; k++) m_s1[k] = amp_of(m_acc[k]);
    ld = m_hold && !sync_in && (m_cnt >= CR);
    for (int k = 0; k < CR; k++) begin
      if (ld) m_acc[k] = init_phase + PW'(k) * freq_word;
      else if (!m_hold && enable) m_acc[k] = m_acc[k] + PW'(CR) * freq_word;
    end
    if (m_hold) begin
      if (m_cnt != CR) m_cnt++;
      if (ld) m_hold = 1'b0;
    end else if (sync_in) begin
      m_hold = 1'b1; m_cnt = 1;
    end
    @(negedge clk);
    check(m_v2 ? tag : "R3", int'(out_valid), int'(m_v2));
    for (int k = 0; k < CR; k++) begin
      check(m_v2 ? tag : "R3", lane_out(k), m_s2[k]);
      n_chk++;
      if (lane_out(k) > 2047 || lane_out(k) < -2047) begin
        n_bad++;
        $display("FAIL R8 actual=%0d expected=|x|<=2047", lane_out(k));
      end
    end
  endtask

  // sync pulse of L edges, then wait for valid; checks load timing (R5)
  task automatic sync_run(input int len, input logic [PW-1:0] f, input logic [PW-1:0] p);
    int edges;
    bit seen_low;
    int exp_n;
    bit first;
    edges = 0; seen_low = 1'b0; first = 1'b1;
    sync_in = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (i == 1) begin freq_word = f; init_phase = p; end
      step("R5"); edges++;
      if (!out_valid) seen_low = 1'b1;
    end
    if (len == 1) begin freq_word = f; init_phase = p; end
    sync_in = 1'b0;
    while (!(out_valid && seen_low) && edges < 40) begin
      step("R5"); edges++;
      if (!out_valid) seen_low = 1'b1;
    end
    exp_n = ((len > CR) ? len : CR) + 3;
    check("R5", edges, exp_n);
    // R2: first valid word holds the loaded lane phases
    for (int k = 0; k < CR; k++)
      if (first) check("R2", lane_out(k), amp_of(p + PW'(k) * f));
  endtask

  initial begin
    logic [PW-1:0] fl [7];
    logic [PW-1:0] pl [3];
    int edges;
    fl = '{16'h0001, 16'h0100, 16'h0400, 16'h1234, 16'h7FFF, 16'h8000, 16'hFFFF};
    pl = '{16'h0000, 16'h4000, 16'hC321};
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_samples == '0), 1);
    freq_word = 16'h0123; init_phase = 16'h0000;
    rst_n = 1'b1;
    edges = 0;
    while (!out_valid && edges < 40) begin step("R1"); edges++; end
    check("R1", edges, CR + 3);
    repeat (10) step("R4");

    // sweep sync length x frequency x phase
    for (int li = 1; li <= 7; li++)
      for (int fi = 0; fi < 7; fi++)
        for (int pi = 0; pi < 3; pi++) begin
          sync_run(li, fl[fi], pl[pi]);
          repeat (8) step((fl[fi] == 16'h0100) ? "R7" : "R4");
        end

    // R7: full table walk over all four quadrants
    sync_run(2, 16'h0100, 16'h0000);
    repeat (70) step("R7");

    // R6: pauses keep phase
    sync_run(3, 16'h0A31, 16'h1111);
    repeat (4) step("R4");
    enable = 1'b0;
    repeat (3) step("R6");
    check("R6", int'(out_valid), 0);
    enable = 1'b1;
    repeat (6) step("R6");
    enable = 1'b0; step("R6"); enable = 1'b1;
    repeat (6) step("R6");

    // R9: sync re-raised inside the stretch
    sync_in = 1'b1; step("R9");
    sync_in = 1'b0; step("R9");
    sync_in = 1'b1; step("R9");
    sync_in = 1'b0;
    edges = 3;
    while (!out_valid && edges < 40) begin step("R9"); edges++; end
    check("R9", edges, CR + 3);
    repeat (6) step("R9");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule